// File: doc/BRIEF.md
# I2C Target Data-Phase Responder

This block runs the data phase of an I2C target once a byte-level bus engine has reported an address match. In a read transfer it hands the engine one byte at a time from a bounded local source. When the source runs out, it sends zero bytes until the controller ends the transfer. In a write transfer it stores each received byte into a local sink up to that sink's capacity. Any bytes beyond the capacity are still accepted on the bus but are dropped.

The engine signals single-cycle events: transmit buffer empty, byte transferred and acknowledged, NACK received, STOP seen, received byte valid, and a new address match (a repeated START). The responder resolves events that arrive in the same cycle by a fixed priority. When a transfer ends, it emits one done pulse that carries a termination code and the final byte count. When it acts on a STOP, it also returns a one-cycle clear strobe to the engine. The engine uses that strobe to drop its sticky STOP flag, in the same way that software would read the status register and then write the control register.

Top module: `i2c_target_responder`

## Requirements
- R1: In a read transfer, the k-th byte loaded (`tx_load` high, k counted from 0) is `src_byte` taken at `src_idx`=k when k < `src_len`, and 0x00 otherwise; the load appears the cycle after `bus_tx_empty`.
- R2: A read transfer counts one byte for each acknowledged transfer (`bus_tx_done`) and one for a NACKed byte; a NACK after a loaded byte ends it with `done_code`=2 and a count that includes that byte (codes: 0 STOP, 1 repeated START, 2 NACK, 3 bus error).
- R3: In a write transfer, received bytes go out on `snk_we` at `snk_idx` 0,1,2... while the stored count is below `snk_cap`; later bytes produce no `snk_we`, and the done count is the stored count.
- R4: While a loaded byte is in flight, events are resolved in the order NACK, byte-done, STOP, repeated START; a lower event in the same cycle is ignored.
- R5: In a write transfer, a byte that is valid in the same cycle as STOP or repeated START is stored and counted before the transfer ends.
- R6: NACK, STOP or repeated START arriving in a read before the first `bus_tx_empty` ends it with count 0, code 2, 0 or 1 respectively, and loads no byte.
- R7: NACK, STOP or repeated START arriving in a read after at least one completed byte, while waiting for the next `bus_tx_empty`, ends it with code 3 and the completed count.
- R8: `stop_clear` pulses for exactly the cycle of a done pulse that was caused by a STOP (code 0 or 3), and at no other time.
- R9: A repeated START ends the running transfer with code 1 and immediately begins a new transfer in the direction given by `addr_rd`, with its count restarted at 0.
- R10: Byte counts saturate at 2^CNT_W-1; further bytes leave the count there and, in a read, are sent as padding.
- R11: After reset, all outputs are 0 and the block waits for an address match; all pulse outputs and their data fields are 0 outside their pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_hit | input | 1 | Address match (new START or repeated START) |
| addr_rd | input | 1 | Direction of the match, 1 = controller reads |
| bus_tx_empty | input | 1 | Engine can take a byte to transmit |
| bus_tx_done | input | 1 | Transmitted byte finished and acknowledged |
| bus_nack | input | 1 | Controller NACKed the transmitted byte |
| bus_stop | input | 1 | STOP condition detected |
| bus_rx_valid | input | 1 | Received byte available |
| bus_rx_byte | input | 8 | Received byte |
| src_len | input | CNT_W | Number of valid source bytes |
| src_byte | input | 8 | Source byte at `src_idx` |
| src_idx | output | CNT_W | Index of the next byte to send |
| snk_cap | input | CNT_W | Sink capacity in bytes |
| tx_load | output | 1 | Load `tx_byte` into the engine |
| tx_byte | output | 8 | Byte to transmit |
| stop_clear | output | 1 | Clear strobe for the engine's STOP flag |
| snk_we | output | 1 | Store `snk_byte` at `snk_idx` |
| snk_idx | output | CNT_W | Sink write index |
| snk_byte | output | 8 | Sink write data |
| done | output | 1 | Transfer-ended pulse |
| done_code | output | 2 | Termination code |
| done_count | output | CNT_W | Final byte count |

## Verification
The reference model is stepped on every clock and compared against the design. It is driven through reads that are shorter than, equal to and longer than the source, so that real data, the switch to padding and counter saturation can each be told apart. Writes are run below and above the sink capacity, which separates stored bytes from discarded ones. Event pile-ups in one cycle (NACK with byte-done and STOP, byte-done with STOP, data with STOP, STOP with repeated START) show whether the priority order is kept. Terminations placed before the first byte and between bytes show the zero-length outcome apart from the bus-error outcome.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_RD_FIRST = 3'd1,
      ST_RD_BUSY = 3'd2,
      ST_RD_NEXT = 3'd3,
      ST_WR      = 3'd4
   } rsp_state_t;

   typedef enum logic [1:0] {
      END_STOP    = 2'd0,
      END_RESTART = 2'd1,
      END_NACK    = 2'd2,
      END_BUSERR  = 2'd3
   } end_code_t;
endpackage

// File: rtl/i2cr_sat_cnt.sv
module i2cr_sat_cnt #(
   parameter int W        = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q,
   output logic [W-1:0] q_inc
);
   localparam logic [W-1:0] TOP = '1;

   generate
      if (SATURATE) begin : g_sat
         assign q_inc = (q == TOP) ? TOP : q + 1'b1;
         // R10
         sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q == TOP && inc && !clr) |=> (q == TOP));
      end else begin : g_wrap
         assign q_inc = q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (inc) q <= q_inc;
   end
endmodule

// File: rtl/i2cr_tx_pick.sv
module i2cr_tx_pick #(
   parameter int         W   = 8,
   parameter logic [7:0] PAD = 8'h00
) (
   input  logic [W-1:0] idx,
   input  logic [W-1:0] len,
   input  logic [7:0]   data,
   output logic [7:0]   byte_o
);
   assign byte_o = (idx < len) ? data : PAD;
endmodule

// File: rtl/i2cr_rx_gate.sv
module i2cr_rx_gate #(
   parameter int W = 8
) (
   input  logic         valid,
   input  logic [W-1:0] idx,
   input  logic [W-1:0] cap,
   output logic         keep
);
   assign keep = valid && (idx < cap);
endmodule

// File: rtl/i2c_target_responder.sv
module i2c_target_responder
   import i2cr_pkg::*;
#(
   parameter int         CNT_W    = 8,
   parameter logic [7:0] PAD_BYTE = 8'h00,
   parameter bit         SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_hit,
   input  logic             addr_rd,
   input  logic             bus_tx_empty,
   input  logic             bus_tx_done,
   input  logic             bus_nack,
   input  logic             bus_stop,
   input  logic             bus_rx_valid,
   input  logic [7:0]       bus_rx_byte,
   input  logic [CNT_W-1:0] src_len,
   input  logic [7:0]       src_byte,
   output logic [CNT_W-1:0] src_idx,
   input  logic [CNT_W-1:0] snk_cap,
   output logic             tx_load,
   output logic [7:0]       tx_byte,
   output logic             stop_clear,
   output logic             snk_we,
   output logic [CNT_W-1:0] snk_idx,
   output logic [7:0]       snk_byte,
   output logic             done,
   output logic [1:0]       done_code,
   output logic [CNT_W-1:0] done_count
);
   initial begin
      param_range_chk: assert (CNT_W >= 2 && CNT_W <= 16)
         else $fatal(1, "CNT_W out of range");
   end

   rsp_state_t       st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_inc_v, cnt_now;
   logic             cnt_clr, cnt_inc;
   logic [7:0]       pick_byte;
   logic             rx_keep;
   logic             ld_d, end_d, we_d, sclr_d, start_new;
   end_code_t        code_d;
   logic [CNT_W-1:0] count_d;

   i2cr_sat_cnt #(.W(CNT_W), .SATURATE(SATURATE)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
      .q(cnt_q), .q_inc(cnt_inc_v)
   );

   i2cr_tx_pick #(.W(CNT_W), .PAD(PAD_BYTE)) u_pick (
      .idx(cnt_q), .len(src_len), .data(src_byte), .byte_o(pick_byte)
   );

   i2cr_rx_gate #(.W(CNT_W)) u_gate (
      .valid(bus_rx_valid), .idx(cnt_q), .cap(snk_cap), .keep(rx_keep)
   );

   assign src_idx = cnt_q;

   always_comb begin
      st_d      = st_q;
      cnt_clr   = 1'b0;
      cnt_inc   = 1'b0;
      ld_d      = 1'b0;
      end_d     = 1'b0;
      we_d      = 1'b0;
      sclr_d    = 1'b0;
      start_new = 1'b0;
      code_d    = END_STOP;
      count_d   = cnt_q;
      cnt_now   = cnt_q;
      unique case (st_q)
         ST_IDLE: begin
            if (addr_hit) start_new = 1'b1;
         end
         ST_RD_FIRST: begin
            if (bus_nack) begin
               end_d = 1'b1; code_d = END_NACK; st_d = ST_IDLE;
            end else if (bus_stop) begin
               end_d = 1'b1; code_d = END_STOP; sclr_d = 1'b1; st_d = ST_IDLE;
            end else if (addr_hit) begin
               end_d = 1'b1; code_d = END_RESTART; start_new = 1'b1;
            end else if (bus_tx_empty) begin
               ld_d = 1'b1; st_d = ST_RD_BUSY;
            end
         end
         ST_RD_BUSY: begin
            if (bus_nack) begin
               cnt_inc = 1'b1; end_d = 1'b1; code_d = END_NACK;
               count_d = cnt_inc_v; st_d = ST_IDLE;
            end else if (bus_tx_done) begin
               cnt_inc = 1'b1; st_d = ST_RD_NEXT;
            end else if (bus_stop) begin
               end_d = 1'b1; code_d = END_STOP; sclr_d = 1'b1; st_d = ST_IDLE;
            end else if (addr_hit) begin
               end_d = 1'b1; code_d = END_RESTART; start_new = 1'b1;
            end
         end
         ST_RD_NEXT: begin
            if (bus_nack || bus_stop || addr_hit) begin
               end_d = 1'b1; code_d = END_BUSERR; sclr_d = bus_stop;
               st_d = ST_IDLE;
            end else if (bus_tx_empty) begin
               ld_d = 1'b1; st_d = ST_RD_BUSY;
            end
         end
         ST_WR: begin
            if (rx_keep) begin
               we_d = 1'b1; cnt_inc = 1'b1; cnt_now = cnt_inc_v;
            end
            count_d = cnt_now;
            if (addr_hit) begin
               end_d = 1'b1; code_d = END_RESTART; start_new = 1'b1;
            end else if (bus_stop) begin
               end_d = 1'b1; code_d = END_STOP; sclr_d = 1'b1; st_d = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
      if (start_new) begin
         cnt_clr = 1'b1;
         st_d    = addr_rd ? ST_RD_FIRST : ST_WR;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         tx_load    <= 1'b0;
         tx_byte    <= 8'h00;
         stop_clear <= 1'b0;
         snk_we     <= 1'b0;
         snk_idx    <= '0;
         snk_byte   <= 8'h00;
         done       <= 1'b0;
         done_code  <= 2'd0;
         done_count <= '0;
      end else begin
         st_q       <= st_d;
         tx_load    <= ld_d;
         tx_byte    <= ld_d ? pick_byte : 8'h00;
         stop_clear <= sclr_d;
         snk_we     <= we_d;
         snk_idx    <= we_d ? cnt_q : '0;
         snk_byte   <= we_d ? bus_rx_byte : 8'h00;
         done       <= end_d;
         done_code  <= end_d ? code_d : END_STOP;
         done_count <= end_d ? count_d : '0;
      end
   end

   // R1
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && ($past(src_idx) >= $past(src_len))) |-> (tx_byte == PAD_BYTE));

   // R3
   sink_in_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snk_we |-> (snk_idx < $past(snk_cap)));

   // R8
   stop_clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_clear |-> (done && (done_code == END_STOP || done_code == END_BUSERR)));

   // R6
   done_load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, tx_load}));
endmodule

// File: tb/tb_i2c_target_responder.sv
`timescale 1ns/1ps
module tb_i2c_target_responder;
   localparam int CW  = 4;
   localparam int MAX = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic addr_hit = 0, addr_rd = 0, tx_empty = 0, tx_done = 0, nack = 0, stop = 0, rx_valid = 0;
   logic [7:0] rx_byte = 8'h00;
   logic [CW-1:0] src_len = '0, snk_cap = '0;
   logic [CW-1:0] src_idx, snk_idx, done_count;
   logic [7:0] src_byte, tx_byte, snk_byte;
   logic tx_load, stop_clear, snk_we, done;
   logic [1:0] done_code;
   logic [7:0] src_mem [16];

   always #5 clk = ~clk;

   assign src_byte = src_mem[src_idx];

   i2c_target_responder #(.CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .addr_hit(addr_hit), .addr_rd(addr_rd),
      .bus_tx_empty(tx_empty), .bus_tx_done(tx_done), .bus_nack(nack),
      .bus_stop(stop), .bus_rx_valid(rx_valid), .bus_rx_byte(rx_byte),
      .src_len(src_len), .src_byte(src_byte), .src_idx(src_idx),
      .snk_cap(snk_cap), .tx_load(tx_load), .tx_byte(tx_byte),
      .stop_clear(stop_clear), .snk_we(snk_we), .snk_idx(snk_idx),
      .snk_byte(snk_byte), .done(done), .done_code(done_code),
      .done_count(done_count)
   );

   int n_chk = 0, n_fail = 0;

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Behavioural reference model
   int m = 0, mcnt = 0;
   int e_ld, e_tb, e_dn, e_cd, e_ct, e_we, e_si, e_sb, e_sc;
   initial begin
      e_ld = 0; e_tb = 0; e_dn = 0; e_cd = 0; e_ct = 0;
      e_we = 0; e_si = 0; e_sb = 0; e_sc = 0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m = 0; mcnt = 0;
         e_ld = 0; e_tb = 0; e_dn = 0; e_cd = 0; e_ct = 0;
         e_we = 0; e_si = 0; e_sb = 0; e_sc = 0;
      end else begin
         automatic bit st = 0;
         automatic int pk = (mcnt < int'(src_len)) ? int'(src_mem[mcnt]) : 0;
         e_ld = 0; e_tb = 0; e_dn = 0; e_cd = 0; e_ct = 0;
         e_we = 0; e_si = 0; e_sb = 0; e_sc = 0;
         if (m == 0) begin
            if (addr_hit) st = 1;
         end else if (m == 1) begin
            if (nack) begin e_dn = 1; e_cd = 2; e_ct = 0; m = 0; end
            else if (stop) begin e_dn = 1; e_cd = 0; e_ct = 0; e_sc = 1; m = 0; end
            else if (addr_hit) begin e_dn = 1; e_cd = 1; e_ct = 0; st = 1; end
            else if (tx_empty) begin e_ld = 1; e_tb = pk; m = 2; end
         end else if (m == 2) begin
            if (nack) begin
               mcnt = (mcnt == MAX) ? MAX : mcnt + 1;
               e_dn = 1; e_cd = 2; e_ct = mcnt; m = 0;
            end else if (tx_done) begin
               mcnt = (mcnt == MAX) ? MAX : mcnt + 1; m = 3;
            end else if (stop) begin e_dn = 1; e_cd = 0; e_ct = mcnt; e_sc = 1; m = 0; end
            else if (addr_hit) begin e_dn = 1; e_cd = 1; e_ct = mcnt; st = 1; end
         end else if (m == 3) begin
            if (nack || stop || addr_hit) begin
               e_dn = 1; e_cd = 3; e_ct = mcnt; e_sc = stop ? 1 : 0; m = 0;
            end else if (tx_empty) begin e_ld = 1; e_tb = pk; m = 2; end
         end else begin
            if (rx_valid && mcnt < int'(snk_cap)) begin
               e_we = 1; e_si = mcnt; e_sb = int'(rx_byte); mcnt = mcnt + 1;
            end
            if (addr_hit) begin e_dn = 1; e_cd = 1; e_ct = mcnt; st = 1; end
            else if (stop) begin e_dn = 1; e_cd = 0; e_ct = mcnt; e_sc = 1; m = 0; end
         end
         if (st) begin mcnt = 0; m = addr_rd ? 1 : 4; end
      end
   end

   // Per-cycle comparison and event capture
   int last_code = -1, last_count = -1, n_done = 0, n_we = 0, n_sc = 0;
   logic [7:0] txq [$];

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R1 tx_load", int'(tx_load), e_ld);
         chk("R1 tx_byte", int'(tx_byte), e_tb);
         chk("R3 snk_we", int'(snk_we), e_we);
         chk("R3 snk_idx", int'(snk_idx), e_si);
         chk("R3 snk_byte", int'(snk_byte), e_sb);
         chk("R2 done", int'(done), e_dn);
         chk("R2 done_code", int'(done_code), e_cd);
         chk("R2 done_count", int'(done_count), e_ct);
         chk("R8 stop_clear", int'(stop_clear), e_sc);
         if (done) begin
            n_done++; last_code = int'(done_code); last_count = int'(done_count);
         end
         if (snk_we) n_we++;
         if (stop_clear) n_sc++;
         if (tx_load) txq.push_back(tx_byte);
      end
   end

   task automatic ev(bit a, bit rd, bit te, bit td, bit nk, bit sp, bit rv, logic [7:0] rb);
      addr_hit = a; addr_rd = rd; tx_empty = te; tx_done = td;
      nack = nk; stop = sp; rx_valid = rv; rx_byte = rb;
      @(negedge clk);
      addr_hit = 0; tx_empty = 0; tx_done = 0; nack = 0;
      stop = 0; rx_valid = 0; rx_byte = 8'h00;
   endtask

   task automatic gap(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr_cap();
      gap(2);
      n_done = 0; n_we = 0; n_sc = 0; last_code = -1; last_count = -1;
      txq.delete();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) src_mem[i] = 8'hA0 + 8'(i);
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 tx_load", int'(tx_load), 0);
      chk("R11 done", int'(done), 0);
      chk("R11 snk_we", int'(snk_we), 0);
      chk("R11 stop_clear", int'(stop_clear), 0);
      chk("R11 src_idx", int'(src_idx), 0);
      rst_n = 1'b1;
      gap(2);

      // R1 R2 read within source
      clr_cap(); src_len = 4'd5;
      ev(1,1,0,0,0,0,0,0);
      for (int k = 0; k < 3; k++) begin
         ev(0,0,1,0,0,0,0,0);
         if (k < 2) ev(0,0,0,1,0,0,0,0); else ev(0,0,0,0,1,0,0,0);
      end
      gap(2);
      chk("R2 nack code", last_code, 2);
      chk("R2 nack count", last_count, 3);
      chk("R1 byte2", int'(txq[2]), 8'hA2);

      // R1 padding past source
      clr_cap(); src_len = 4'd2;
      ev(1,1,0,0,0,0,0,0);
      for (int k = 0; k < 4; k++) begin
         ev(0,0,1,0,0,0,0,0);
         if (k < 3) ev(0,0,0,1,0,0,0,0); else ev(0,0,0,0,1,0,0,0);
      end
      gap(2);
      chk("R1 pad count", last_count, 4);
      chk("R1 real byte", int'(txq[1]), 8'hA1);
      chk("R1 pad byte", int'(txq[3]), 0);

      // R3 R8 write within capacity
      clr_cap(); snk_cap = 4'd5;
      ev(1,0,0,0,0,0,0,0);
      ev(0,0,0,0,0,0,1,8'h11); ev(0,0,0,0,0,0,1,8'h22); ev(0,0,0,0,0,0,1,8'h33);
      ev(0,0,0,0,0,1,0,0);
      gap(2);
      chk("R3 stored", n_we, 3);
      chk("R3 count", last_count, 3);
      chk("R8 stop code", last_code, 0);
      chk("R8 clear pulses", n_sc, 1);

      // R3 overflow discarded
      clr_cap(); snk_cap = 4'd2;
      ev(1,0,0,0,0,0,0,0);
      for (int k = 0; k < 6; k++) ev(0,0,0,0,0,0,1,8'(k));
      ev(0,0,0,0,0,1,0,0);
      gap(2);
      chk("R3 overflow stored", n_we, 2);
      chk("R3 overflow count", last_count, 2);

      // R5 data with stop
      clr_cap(); snk_cap = 4'd5;
      ev(1,0,0,0,0,0,0,0);
      ev(0,0,0,0,0,0,1,8'h44);
      ev(0,0,0,0,0,1,1,8'h55);
      gap(2);
      chk("R5 count", last_count, 2);
      chk("R5 stored", n_we, 2);

      // R4 priority
      clr_cap(); src_len = 4'd5;
      ev(1,1,0,0,0,0,0,0);
      ev(0,0,1,0,0,0,0,0);
      ev(0,0,0,1,1,1,0,0);
      gap(2);
      chk("R4 nack wins code", last_code, 2);
      chk("R4 nack wins count", last_count, 1);
      clr_cap();
      ev(1,1,0,0,0,0,0,0);
      ev(0,0,1,0,0,0,0,0);
      ev(0,0,0,1,0,1,0,0);
      gap(1);
      chk("R4 done over stop", n_done, 0);
      ev(0,0,1,0,0,0,0,0);
      ev(1,1,0,0,0,1,0,0);
      gap(2);
      chk("R4 stop over restart", last_code, 0);
      chk("R4 count", last_count, 1);
      chk("R4 second byte", int'(txq[1]), 8'hA1);

      // R6 zero-length reads
      clr_cap();
      ev(1,1,0,0,0,0,0,0); ev(0,0,0,0,1,0,0,0);
      gap(2);
      chk("R6 nack code", last_code, 2);
      chk("R6 nack count", last_count, 0);
      ev(1,1,0,0,0,0,0,0); ev(0,0,0,0,0,1,0,0);
      gap(2);
      chk("R6 stop code", last_code, 0);
      ev(1,1,0,0,0,0,0,0); ev(1,1,0,0,0,0,0,0);
      gap(2);
      chk("R6 restart code", last_code, 1);
      ev(0,0,0,0,1,0,0,0);
      gap(2);
      chk("R6 no loads", int'(txq.size()), 0);
      chk("R6 done total", n_done, 4);

      // R7 bus error between bytes
      clr_cap();
      ev(1,1,0,0,0,0,0,0); ev(0,0,1,0,0,0,0,0); ev(0,0,0,1,0,0,0,0);
      ev(0,0,0,0,0,1,0,0);
      gap(2);
      chk("R7 code", last_code, 3);
      chk("R7 count", last_count, 1);
      chk("R7 clear", n_sc, 1);

      // R9 restart switches direction
      clr_cap(); snk_cap = 4'd5;
      ev(1,0,0,0,0,0,0,0);
      ev(0,0,0,0,0,0,1,8'h01); ev(0,0,0,0,0,0,1,8'h02);
      ev(1,1,0,0,0,0,0,0);
      gap(1);
      chk("R9 restart code", last_code, 1);
      chk("R9 restart count", last_count, 2);
      ev(0,0,1,0,0,0,0,0); ev(0,0,0,0,1,0,0,0);
      gap(2);
      chk("R9 new read byte", int'(txq[0]), 8'hA0);
      chk("R9 new read count", last_count, 1);

      // R10 saturation
      clr_cap(); src_len = 4'd15;
      ev(1,1,0,0,0,0,0,0);
      for (int k = 0; k < 18; k++) begin
         ev(0,0,1,0,0,0,0,0); ev(0,0,0,1,0,0,0,0);
      end
      ev(0,0,1,0,0,0,0,0); ev(0,0,0,0,1,0,0,0);
      gap(2);
      chk("R10 saturated count", last_count, MAX);
      chk("R10 loads", int'(txq.size()), 19);
      chk("R10 last real", int'(txq[14]), 8'hAE);
      chk("R10 pad after max", int'(txq[18]), 0);

      gap(3);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule